// File: doc/BRIEF.md
# Pipeline Issue Slot Classifier

This block watches the hand-off point between a processor's front end (fetch and decode) and its back end (execute and retire). Every clock cycle it accounts for a fixed number of issue slots, four by default. It places each slot in exactly one of four categories:

- **Retiring**: the slot's micro-op completed normally.
- **Front-End-Bound**: the back end could have taken a micro-op but the front end left the slot empty.
- **Back-End-Bound**: the back end refused micro-ops in that cycle.
- **Bad Speculation**: the slot's micro-op was cancelled, or the slot stayed empty while the machine recovered from a flush.

Each category has its own saturating event counter. A fifth counter holds the total number of slots. A snapshot strobe copies all five counters at once into read registers, so software always reads one consistent set.

Slots that carry an issued micro-op are not classified when they are issued. They are classified later, when the pipeline reports them as retired or as cancelled. The four category counters therefore add up to the total only once every issued micro-op has resolved.

Top module: `slot_census`

## Requirements
- R1: When `clr` is low and the total counter is not saturated, the total counter rises by exactly SLOTS (4) every cycle.
- R2: With `be_ready` low, the Back-End-Bound counter rises by SLOTS. The Front-End-Bound counter does not change, whatever `fe_count` and `recovering` are.
- R3: With `be_ready` high and `recovering` low, the Front-End-Bound counter rises by SLOTS minus the number of micro-ops delivered.
- R4: With `be_ready` high and `recovering` high, the empty slots are added to Bad Speculation and the Front-End-Bound counter holds.
- R5: Every cycle, `retired_n` is added to the Retiring counter, whatever the state of `be_ready`.
- R6: Every cycle, `cancelled_n` is added to the Bad Speculation counter, on top of any empty slots added during recovery.
- R7: Once every issued micro-op has been reported as retired or cancelled, the four category counters sum to the total counter.
- R8: Every counter stops at its all-ones value (2^CW-1) and never wraps.
- R9: A high `clr` sets all five live counters to zero at the next edge, overriding that cycle's increments. The read registers are left unchanged.
- R10: A high `snap` loads each read register with the value its live counter holds before that edge. Otherwise the read registers hold their value.
- R11: While `rst_n` is low, every live counter and every read register is zero at each clock edge, and `snap` and the counting inputs have no effect.
- R12: A `fe_count` above SLOTS (values 5 to 7) counts as SLOTS delivered micro-ops, which gives zero Front-End-Bound or recovery slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the live counters |
| snap | input | 1 | Copy the live counters into the read registers |
| be_ready | input | 1 | Back end can accept micro-ops this cycle |
| recovering | input | 1 | Machine is refilling after a flush |
| fe_count | input | UW (3) | Micro-ops offered by the front end this cycle |
| retired_n | input | UW (3) | Micro-ops retired this cycle |
| cancelled_n | input | UW (3) | Micro-ops cancelled by a flush this cycle |
| cnt_retire | output | CW (32) | Live Retiring counter |
| cnt_fe | output | CW (32) | Live Front-End-Bound counter |
| cnt_be | output | CW (32) | Live Back-End-Bound counter |
| cnt_bs | output | CW (32) | Live Bad Speculation counter |
| cnt_total | output | CW (32) | Live total-slot counter |
| rd_retire | output | CW (32) | Read copy of the Retiring counter |
| rd_fe | output | CW (32) | Read copy of the Front-End-Bound counter |
| rd_be | output | CW (32) | Read copy of the Back-End-Bound counter |
| rd_bs | output | CW (32) | Read copy of the Bad Speculation counter |
| rd_total | output | CW (32) | Read copy of the total counter |

## Verification
On every cycle the assertions check these relations:

- the per-cycle step of the total counter;
- the Back-End-Bound step during a stall, and the Front-End-Bound counter holding during a stall and during recovery;
- the Front-End-Bound step from `fe_count`;
- the Retiring and cancellation steps;
- saturation with no wrap;
- clear and reset to zero;
- the snapshot copy of the previous live values.

Some behaviours can only be shown by the bench's scenarios, because they depend on a history of cycles:

- the balance of the four categories against the total once in-flight micro-ops have drained;
- clamping of oversized `fe_count` values;
- read registers that hold their value across a clear.

// File: rtl/slot_census_pkg.sv
// Package: shared category encoding for the issue slot classifier.
// Assumes categories are used as indices 0..NCAT-1 of packed increment arrays.
package slot_census_pkg;
    typedef enum logic [1:0] {
        CAT_RET = 2'd0,
        CAT_FE  = 2'd1,
        CAT_BE  = 2'd2,
        CAT_BS  = 2'd3
    } slot_cat_e;

    localparam int NCAT = 4;
endpackage

// File: rtl/slot_sorter.sv
// Module: slot_sorter
// Turns one cycle's pipeline status into a per-category increment.
// Issued slots are not counted here. They are settled later through the
// retired and cancelled counts. Assumes IW can hold SLOTS + (2**UW - 1).
module slot_sorter
    import slot_census_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int UW    = 3,
    parameter int IW    = 4
) (
    input  logic                       be_ready,
    input  logic                       recovering,
    input  logic [UW-1:0]              fe_count,
    input  logic [UW-1:0]              retired_n,
    input  logic [UW-1:0]              cancelled_n,
    output logic [NCAT-1:0][IW-1:0]    inc
);
    localparam logic [UW-1:0] SLOTS_U = UW'(SLOTS);

    logic [UW-1:0] delivered;
    logic [UW-1:0] empty;

    // Clamp the offered count to the slot width and derive the empty slots.
    always_comb begin
        delivered = (fe_count > SLOTS_U) ? SLOTS_U : fe_count;
        empty     = SLOTS_U - delivered;
    end

    // Route this cycle's slots: a back-end stall wins over supply and recovery.
    always_comb begin
        inc              = '0;
        inc[int'(CAT_RET)] = IW'(retired_n);
        inc[int'(CAT_BS)]  = IW'(cancelled_n);
        if (!be_ready) begin
            inc[int'(CAT_BE)] = IW'(SLOTS);
        end else if (recovering) begin
            inc[int'(CAT_BS)] = IW'(cancelled_n) + IW'(empty);
        end else begin
            inc[int'(CAT_FE)] = IW'(empty);
        end
    end
endmodule

// File: rtl/sat_accum.sv
// Module: sat_accum
// Saturating event counter with a synchronous active-low reset and a
// synchronous clear. Assumes IW < CW + 1.
module sat_accum #(
    parameter int CW = 32,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [IW-1:0] inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW:0] LIMIT = {1'b0, {CW{1'b1}}};

    logic [CW:0] sum;

    // Form the widened sum so that an overflow can be seen.
    always_comb sum = {1'b0, cnt} + (CW+1)'(inc);

    // Count up, holding at all-ones; reset and clear both return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (sum > LIMIT) cnt <= {CW{1'b1}};
        else                cnt <= sum[CW-1:0];
    end
endmodule

// File: rtl/slot_census.sv
// Module: slot_census (top)
// Sorts SLOTS issue slots per cycle into four categories, keeps saturating
// live counters for each category and for the total, and copies all five
// into read registers on a snapshot strobe. Assumes the inputs are sampled
// once per clock and that retired/cancelled counts refer to issued micro-ops.
module slot_census
    import slot_census_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int CW    = 32,
    parameter int UW    = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          snap,
    input  logic          be_ready,
    input  logic          recovering,
    input  logic [UW-1:0] fe_count,
    input  logic [UW-1:0] retired_n,
    input  logic [UW-1:0] cancelled_n,
    output logic [CW-1:0] cnt_retire,
    output logic [CW-1:0] cnt_fe,
    output logic [CW-1:0] cnt_be,
    output logic [CW-1:0] cnt_bs,
    output logic [CW-1:0] cnt_total,
    output logic [CW-1:0] rd_retire,
    output logic [CW-1:0] rd_fe,
    output logic [CW-1:0] rd_be,
    output logic [CW-1:0] rd_bs,
    output logic [CW-1:0] rd_total
);
    localparam int IW = UW + 1;

    logic [NCAT-1:0][IW-1:0] inc;
    logic [CW-1:0]           live [NCAT];
    logic [CW-1:0]           rd   [NCAT];

    slot_sorter #(.SLOTS(SLOTS), .UW(UW), .IW(IW)) u_sorter (
        .be_ready    (be_ready),
        .recovering  (recovering),
        .fe_count    (fe_count),
        .retired_n   (retired_n),
        .cancelled_n (cancelled_n),
        .inc         (inc)
    );

    // One saturating counter per category.
    for (genvar c = 0; c < NCAT; c++) begin : g_cat
        sat_accum #(.CW(CW), .IW(IW)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc[c]),
            .cnt   (live[c])
        );
    end

    // The total counter advances by the slot width each cycle.
    sat_accum #(.CW(CW), .IW(IW)) u_total (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (IW'(SLOTS)),
        .cnt   (cnt_total)
    );

    // Read registers for the categories: load the pre-edge live values on snap.
    for (genvar c = 0; c < NCAT; c++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)    rd[c] <= '0;
            else if (snap) rd[c] <= live[c];
        end
    end

    // Read register for the total, loaded on the same strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    rd_total <= '0;
        else if (snap) rd_total <= cnt_total;
    end

    assign cnt_retire = live[int'(CAT_RET)];
    assign cnt_fe     = live[int'(CAT_FE)];
    assign cnt_be     = live[int'(CAT_BE)];
    assign cnt_bs     = live[int'(CAT_BS)];
    assign rd_retire  = rd[int'(CAT_RET)];
    assign rd_fe      = rd[int'(CAT_FE)];
    assign rd_be      = rd[int'(CAT_BE)];
    assign rd_bs      = rd[int'(CAT_BS)];
endmodule

// File: rtl/slot_census_chk.sv
// Module: slot_census_chk
// Cycle-level properties of slot_census, bound to every instance of the top.
module slot_census_chk #(
    parameter int SLOTS = 4,
    parameter int CW    = 32,
    parameter int UW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          snap,
    input logic          be_ready,
    input logic          recovering,
    input logic [UW-1:0] fe_count,
    input logic [UW-1:0] retired_n,
    input logic [UW-1:0] cancelled_n,
    input logic [CW-1:0] cnt_retire,
    input logic [CW-1:0] cnt_fe,
    input logic [CW-1:0] cnt_be,
    input logic [CW-1:0] cnt_bs,
    input logic [CW-1:0] cnt_total,
    input logic [CW-1:0] rd_retire,
    input logic [CW-1:0] rd_fe,
    input logic [CW-1:0] rd_be,
    input logic [CW-1:0] rd_bs,
    input logic [CW-1:0] rd_total
);
    localparam logic [CW-1:0] MAX   = '1;
    localparam logic [CW-1:0] HEAD  = MAX - CW'(SLOTS);
    localparam logic [CW-1:0] HEAD2 = MAX - CW'(2 ** UW);

    // R1: total step
    p_total_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_total <= HEAD) |=> cnt_total == $past(cnt_total) + CW'(SLOTS));

    // R2: a stall adds SLOTS to Back-End-Bound
    p_stall_be_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !be_ready && cnt_be <= HEAD) |=> cnt_be == $past(cnt_be) + CW'(SLOTS));

    // R2: a stall leaves Front-End-Bound alone
    p_stall_fe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !be_ready) |=> $stable(cnt_fe));

    // R3: Front-End-Bound step from an in-range offered count
    p_fe_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && be_ready && !recovering && fe_count <= UW'(SLOTS) && cnt_fe <= HEAD)
        |=> cnt_fe == $past(cnt_fe) + CW'(SLOTS) - CW'($past(fe_count)));

    // R4: recovery leaves Front-End-Bound alone
    p_recover_fe_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && recovering) |=> $stable(cnt_fe));

    // R5: retired count lands in Retiring
    p_retire_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_retire <= HEAD2) |=> cnt_retire == $past(cnt_retire) + CW'($past(retired_n)));

    // R6: cancelled count lands in Bad Speculation while stalled
    p_cancel_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !be_ready && cnt_bs <= HEAD2) |=> cnt_bs == $past(cnt_bs) + CW'($past(cancelled_n)));

    // R8: counters never wrap and hold at all-ones
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_retire >= $past(cnt_retire) && cnt_fe >= $past(cnt_fe) &&
                  cnt_be >= $past(cnt_be) && cnt_bs >= $past(cnt_bs) &&
                  cnt_total >= $past(cnt_total)));
    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_total == MAX) |=> cnt_total == MAX);

    // R9: clear zeroes the live set
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_retire == '0 && cnt_fe == '0 && cnt_be == '0 &&
                 cnt_bs == '0 && cnt_total == '0));

    // R10: snapshot copies the pre-edge live values
    p_snap_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (rd_retire == $past(cnt_retire) && rd_fe == $past(cnt_fe) &&
                  rd_be == $past(cnt_be) && rd_bs == $past(cnt_bs) &&
                  rd_total == $past(cnt_total)));
    p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> ($stable(rd_total) && $stable(rd_bs) && $stable(rd_retire)));

    // R11: reset empties every counter and read register
    p_reset_zero_r11: assert property (@(posedge clk)
        !rst_n |=> (cnt_total == '0 && cnt_be == '0 && cnt_bs == '0 &&
                    rd_total == '0 && rd_fe == '0 && rd_be == '0));
endmodule

bind slot_census slot_census_chk #(.SLOTS(SLOTS), .CW(CW), .UW(UW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .snap(snap), .be_ready(be_ready),
    .recovering(recovering), .fe_count(fe_count), .retired_n(retired_n),
    .cancelled_n(cancelled_n), .cnt_retire(cnt_retire), .cnt_fe(cnt_fe),
    .cnt_be(cnt_be), .cnt_bs(cnt_bs), .cnt_total(cnt_total),
    .rd_retire(rd_retire), .rd_fe(rd_fe), .rd_be(rd_be), .rd_bs(rd_bs),
    .rd_total(rd_total)
);

// File: tb/slot_census_test.sv
`timescale 1ns/1ps
// Bench for slot_census: a vector table of inputs and expected per-category
// steps, then directed snapshot, clear, saturation and reset cases.
module slot_census_test;
    localparam int SLOTS = 4;
    localparam int CW    = 10;
    localparam int UW    = 3;
    localparam int NVEC  = 13;

    typedef struct packed {
        logic       be;
        logic       rec;
        logic [2:0] fe;
        logic [2:0] ret;
        logic [2:0] can;
        logic [3:0] d_ret;
        logic [3:0] d_fe;
        logic [3:0] d_be;
        logic [3:0] d_bs;
    } vec_t;

    // be rec fe ret can | expected steps: ret fe be bs
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b0, 3'd4, 3'd0, 3'd0, 4'd0, 4'd0, 4'd0, 4'd0},  // full issue
        '{1'b1, 1'b0, 3'd2, 3'd4, 3'd0, 4'd4, 4'd2, 4'd0, 4'd0},  // R3 R5
        '{1'b0, 1'b0, 3'd4, 3'd2, 3'd0, 4'd2, 4'd0, 4'd4, 4'd0},  // R2 offer ignored
        '{1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 4'd0, 4'd4, 4'd0, 4'd0},  // R3 all bubbles
        '{1'b1, 1'b0, 3'd3, 3'd0, 3'd0, 4'd0, 4'd1, 4'd0, 4'd0},
        '{1'b1, 1'b1, 3'd1, 3'd0, 3'd3, 4'd0, 4'd0, 4'd0, 4'd6},  // R4 R6
        '{1'b1, 1'b1, 3'd0, 3'd0, 3'd0, 4'd0, 4'd0, 4'd0, 4'd4},  // R4
        '{1'b0, 1'b1, 3'd2, 3'd1, 3'd0, 4'd1, 4'd0, 4'd4, 4'd0},  // R2 stall over recovery
        '{1'b1, 1'b0, 3'd7, 3'd0, 3'd0, 4'd0, 4'd0, 4'd0, 4'd0},  // R12
        '{1'b1, 1'b0, 3'd5, 3'd4, 3'd0, 4'd4, 4'd0, 4'd0, 4'd0},  // R12
        '{1'b0, 1'b0, 3'd0, 3'd2, 3'd2, 4'd2, 4'd0, 4'd4, 4'd2},  // R6
        '{1'b1, 1'b0, 3'd1, 3'd0, 3'd0, 4'd0, 4'd3, 4'd0, 4'd0},
        '{1'b1, 1'b0, 3'd0, 3'd1, 3'd0, 4'd1, 4'd4, 4'd0, 4'd0}   // drains
    };

    logic          clk = 1'b0;
    logic          rst_n, clr, snap, be_ready, recovering;
    logic [UW-1:0] fe_count, retired_n, cancelled_n;
    logic [CW-1:0] cnt_retire, cnt_fe, cnt_be, cnt_bs, cnt_total;
    logic [CW-1:0] rd_retire, rd_fe, rd_be, rd_bs, rd_total;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int e_ret, e_fe, e_be, e_bs, e_tot;
    int s_ret, s_fe, s_be, s_bs, s_tot;

    always #10 clk = ~clk;

    slot_census #(.SLOTS(SLOTS), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .snap(snap), .be_ready(be_ready),
        .recovering(recovering), .fe_count(fe_count), .retired_n(retired_n),
        .cancelled_n(cancelled_n), .cnt_retire(cnt_retire), .cnt_fe(cnt_fe),
        .cnt_be(cnt_be), .cnt_bs(cnt_bs), .cnt_total(cnt_total),
        .rd_retire(rd_retire), .rd_fe(rd_fe), .rd_be(rd_be), .rd_bs(rd_bs),
        .rd_total(rd_total)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_live(input string req);
        chk(req, "cnt_retire", int'(cnt_retire), e_ret);
        chk(req, "cnt_fe",     int'(cnt_fe),     e_fe);
        chk(req, "cnt_be",     int'(cnt_be),     e_be);
        chk(req, "cnt_bs",     int'(cnt_bs),     e_bs);
        chk(req, "cnt_total",  int'(cnt_total),  e_tot);
    endtask

    task automatic chk_rd(input string req, input int r, input int f, input int b,
                          input int s, input int t);
        chk(req, "rd_retire", int'(rd_retire), r);
        chk(req, "rd_fe",     int'(rd_fe),     f);
        chk(req, "rd_be",     int'(rd_be),     b);
        chk(req, "rd_bs",     int'(rd_bs),     s);
        chk(req, "rd_total",  int'(rd_total),  t);
    endtask

    task automatic drive(input logic c, input logic sn, input logic be, input logic rc,
                         input int fe, input int rt, input int cn);
        clr = c; snap = sn; be_ready = be; recovering = rc;
        fe_count = UW'(fe); retired_n = UW'(rt); cancelled_n = UW'(cn);
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset with active inputs and snap held high
        rst_n = 1'b0;
        drive(1'b0, 1'b1, 1'b0, 1'b1, 4, 3, 2);
        repeat (3) @(negedge clk);
        e_ret = 0; e_fe = 0; e_be = 0; e_bs = 0; e_tot = 0;
        chk_live("R11");
        chk_rd("R11", 0, 0, 0, 0, 0);

        // Release reset with a clear cycle (R9 from zero)
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 0, 3, 3);
        @(negedge clk);
        chk_live("R9");

        // Vector table (R2 R3 R4 R5 R6 R12, R1 on every row)
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b0, 1'b0, TBL[i].be, TBL[i].rec, int'(TBL[i].fe),
                  int'(TBL[i].ret), int'(TBL[i].can));
            @(negedge clk);
            e_ret += int'(TBL[i].d_ret);
            e_fe  += int'(TBL[i].d_fe);
            e_be  += int'(TBL[i].d_be);
            e_bs  += int'(TBL[i].d_bs);
            e_tot += SLOTS;
            chk_live("R1-table");
        end

        // R7: drained, categories balance the total
        chk("R7", "category sum", int'(cnt_retire) + int'(cnt_fe) + int'(cnt_be) + int'(cnt_bs),
            int'(cnt_total));
        chk("R7", "total", int'(cnt_total), NVEC * SLOTS);

        // R10: snapshot takes the pre-edge values
        s_ret = e_ret; s_fe = e_fe; s_be = e_be; s_bs = e_bs; s_tot = e_tot;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 0, 0, 0);
        @(negedge clk);
        e_fe += SLOTS; e_tot += SLOTS;
        chk_rd("R10", s_ret, s_fe, s_be, s_bs, s_tot);
        chk_live("R10");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 0);
        @(negedge clk);
        e_fe += SLOTS; e_tot += SLOTS;
        chk_rd("R10", s_ret, s_fe, s_be, s_bs, s_tot);
        chk_live("R10");

        // R9: clear together with snap; read set gets the pre-clear values
        drive(1'b1, 1'b1, 1'b0, 1'b0, 4, 3, 2);
        @(negedge clk);
        chk_rd("R9", e_ret, e_fe, e_be, e_bs, e_tot);
        s_ret = e_ret; s_fe = e_fe; s_be = e_be; s_bs = e_bs; s_tot = e_tot;
        e_ret = 0; e_fe = 0; e_be = 0; e_bs = 0; e_tot = 0;
        chk_live("R9");

        // R9: clear alone leaves the read set untouched
        drive(1'b1, 1'b0, 1'b1, 1'b0, 0, 2, 0);
        @(negedge clk);
        chk_live("R9");
        chk_rd("R9", s_ret, s_fe, s_be, s_bs, s_tot);

        // R8: saturation, stalled with full retirement
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2, 4, 0);
        repeat (255) @(negedge clk);
        e_ret = 1020; e_be = 1020; e_tot = 1020;
        chk_live("R8");
        repeat (5) @(negedge clk);
        e_ret = 1023; e_be = 1023; e_tot = 1023;
        chk_live("R8");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule